// File: doc/BRIEF.md
# Management Bus Target Acknowledge Engine

This block is the receive side of a target on a two-wire management bus. It watches the synchronized clock and data lines and finds START, repeated START and STOP. It shifts in the address byte and the bytes that follow it. After every byte it decides whether to pull the data line low in the ninth clock, which is an acknowledge, or to leave it released, which is a not-acknowledge.

The target always acknowledges its own address. This lets a host find out whether the device is present, even when the device is busy. The acknowledge of each byte after the address is controlled by the register layer. For each received byte the engine raises a one-cycle strobe with the byte value. The register layer answers with a single response pulse that marks the byte as accepted or rejected. If no answer arrives in time, the byte is rejected.

Once a byte has been rejected there is no way to resend it. The engine therefore leaves the bus alone until the next START or STOP. Clock stretching, the read direction and packet error checking are not part of this block.

Top module: `mgmt_tgt_ack`

## Requirements
- R1: After reset, `sda_pull_o` is 0 and `data_stb_o` is 0 until a START is seen on the bus.
- R2: The first byte after a START or repeated START is the address byte; the bus sends each byte most significant bit first. When bits [7:1] of that byte equal `own_addr_i`, the engine holds `sda_pull_o` at 1 from the SCL fall after the eighth bit to the SCL fall after the ninth bit. The response inputs have no effect on this.
- R3: When bits [7:1] of the address byte differ from `own_addr_i`, `sda_pull_o` stays 0 and `data_stb_o` stays 0 until the next START or STOP.
- R4: In a write transfer (address bit 0 equal to 0) addressed to the engine, each data byte raises `data_stb_o` for exactly one cycle after its eighth SCL rise. While the strobe is high, `data_o` holds the byte.
- R5: The response window of a data byte runs from its strobe cycle to the cycle in which the SCL fall after its eighth bit is detected. A pulse on `resp_vld_i` in that window with `resp_ok_i`=1 makes the engine acknowledge the byte (pull SDA low in the ninth clock). With `resp_ok_i`=0 the byte is rejected (SDA released).
- R6: If no response arrives in the window, the byte is rejected. A response that arrives after the window has closed does not count.
- R7: Only the first response in a window counts. Later pulses in the same window are ignored.
- R8: The accept or reject decision is made separately for every data byte, including the last one. After a rejected byte, later bytes give no strobe and no pull until the next START or STOP.
- R9: A repeated START (a START without a STOP before it) returns the engine to address reception from any state.
- R10: When address bit 0 is 1 (read), a matching address is still acknowledged. After that the engine releases SDA and gives no strobes until the next START or STOP.
- R11: A STOP at any point, including in the middle of a byte, ends the transfer. The next START begins a fresh address byte with the bit count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level (wired-AND value) |
| own_addr_i | input | ADDR_W | Configured target address |
| resp_vld_i | input | 1 | Response pulse from the register layer for the current byte |
| resp_ok_i | input | 1 | Response value: 1 accept, 0 reject |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_hit_o | output | 1 | One-cycle pulse when the own address is acknowledged |
| data_o | output | BYTE_W | Last received data byte |
| data_stb_o | output | 1 | One-cycle strobe for each received data byte |

## Verification
The bench targets the response window from both sides. It sends a response that arrives one cycle after the SCL fall; a design that latched it late would acknowledge a byte it should reject. It also sends a reject followed by an accept in the same window; a design that let the last pulse win would acknowledge. It rejects the final byte of a transfer and then sends another byte; a design that resumed after the reject would strobe or pull SDA. Further cases are a repeated START with no STOP, a STOP in the middle of a byte, a read address, and mismatching addresses. A design that missed the repeated START, counted bits from the aborted byte, or answered a foreign address would show a wrong acknowledge bit or a wrong received byte.

// File: rtl/mgmt_tgt_pkg.sv
package mgmt_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_AACK = 3'd2,
      ST_DATA = 3'd3,
      ST_DACK = 3'd4,
      ST_SKIP = 3'd5
   } tgt_state_e;

endpackage

// File: rtl/mgmt_bus_cond.sv
module mgmt_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic ev_start_o,
   output logic ev_stop_o,
   output logic ev_rise_o,
   output logic ev_fall_o
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   always_comb begin
      ev_start_o = scl_q & scl_i & sda_q & ~sda_i;
      ev_stop_o  = scl_q & scl_i & ~sda_q & sda_i;
      ev_rise_o  = ~scl_q & scl_i;
      ev_fall_o  = scl_q & ~scl_i;
   end

endmodule

// File: rtl/mgmt_byte_rx.sv
module mgmt_byte_rx #(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = $clog2(BYTE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic              sda_i,
   input  logic              shift_en_i,
   input  logic              clr_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic [CNT_W-1:0]  cnt_o
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("mgmt_byte_rx: BYTE_W must be at least 2");
   end

   logic [BYTE_W-1:0] sreg_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         cnt_q  <= '0;
      end else if (clr_i) begin
         cnt_q  <= '0;
      end else if (rise_i && shift_en_i && (cnt_q != CNT_FULL)) begin
         sreg_q <= {sreg_q[BYTE_W-2:0], sda_i};
         cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   assign byte_o = sreg_q;
   assign cnt_o  = cnt_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL) else $error("bit count past byte width"); // R4

endmodule

// File: rtl/mgmt_resp_latch.sv
module mgmt_resp_latch #(
   parameter bit SAME_CYCLE_RESP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,
   input  logic resp_vld_i,
   input  logic resp_ok_i,
   output logic accept_o
);

   logic seen_q;
   logic ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         ok_q   <= 1'b0;
      end else if (!open_i) begin
         seen_q <= 1'b0;
         ok_q   <= 1'b0;
      end else if (resp_vld_i && !seen_q) begin
         seen_q <= 1'b1;
         ok_q   <= resp_ok_i;
      end
   end

   if (SAME_CYCLE_RESP) begin : g_same_cycle
      assign accept_o = seen_q ? ok_q : (open_i & resp_vld_i & resp_ok_i);
   end else begin : g_latched_only
      assign accept_o = seen_q & ok_q;
   end

   AST_FIRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && open_i) |=> (!open_i || (ok_q == $past(ok_q))))
      else $error("later response overwrote first"); // R7

endmodule

// File: rtl/mgmt_tgt_ack.sv
module mgmt_tgt_ack
   import mgmt_tgt_pkg::*;
#(
   parameter int ADDR_W          = 7,
   parameter int BYTE_W          = 8,
   parameter bit SAME_CYCLE_RESP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              resp_vld_i,
   input  logic              resp_ok_i,
   output logic              sda_pull_o,
   output logic              addr_hit_o,
   output logic [BYTE_W-1:0] data_o,
   output logic              data_stb_o
);

   localparam int               CNT_W    = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   if (BYTE_W != ADDR_W + 1) begin : g_bad_width
      $error("mgmt_tgt_ack: BYTE_W must equal ADDR_W + 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("mgmt_tgt_ack: ADDR_W must be positive");
   end

   logic ev_start, ev_stop, ev_rise, ev_fall;
   logic [BYTE_W-1:0] rx_byte;
   logic [CNT_W-1:0]  rx_cnt;
   logic              rx_full, in_byte, byte_clr, win_open, accept;
   logic              addr_match, rw_bit;

   tgt_state_e state_q;
   logic       pull_q, stb_q, hit_q, ack_clk_q;

   mgmt_bus_cond u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .ev_start_o (ev_start),
      .ev_stop_o  (ev_stop),
      .ev_rise_o  (ev_rise),
      .ev_fall_o  (ev_fall)
   );

   mgmt_byte_rx #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_i     (ev_rise),
      .sda_i      (sda_i),
      .shift_en_i (in_byte),
      .clr_i      (byte_clr),
      .byte_o     (rx_byte),
      .cnt_o      (rx_cnt)
   );

   mgmt_resp_latch #(.SAME_CYCLE_RESP(SAME_CYCLE_RESP)) u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_i     (win_open),
      .resp_vld_i (resp_vld_i),
      .resp_ok_i  (resp_ok_i),
      .accept_o   (accept)
   );

   always_comb begin
      rx_full    = (rx_cnt == CNT_FULL);
      in_byte    = (state_q == ST_ADDR) || (state_q == ST_DATA);
      win_open   = (state_q == ST_DATA) && rx_full;
      addr_match = (rx_byte[BYTE_W-1:1] == own_addr_i);
      rw_bit     = rx_byte[0];
      byte_clr   = ev_start || ev_stop ||
                   (ev_fall && ack_clk_q &&
                    ((state_q == ST_AACK) || (state_q == ST_DACK)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pull_q    <= 1'b0;
         stb_q     <= 1'b0;
         hit_q     <= 1'b0;
         ack_clk_q <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         hit_q <= 1'b0;
         if (ev_start) begin
            state_q   <= ST_ADDR;
            pull_q    <= 1'b0;
            ack_clk_q <= 1'b0;
         end else if (ev_stop) begin
            state_q   <= ST_IDLE;
            pull_q    <= 1'b0;
            ack_clk_q <= 1'b0;
         end else begin
            unique case (state_q)
               ST_ADDR: begin
                  if (ev_fall && rx_full) begin
                     if (addr_match) begin
                        state_q <= ST_AACK;
                        pull_q  <= 1'b1;
                        hit_q   <= 1'b1;
                     end else begin
                        state_q <= ST_SKIP;
                     end
                  end
               end
               ST_DATA: begin
                  if (ev_rise && (rx_cnt == CNT_LAST)) begin
                     stb_q <= 1'b1;
                  end
                  if (ev_fall && rx_full) begin
                     if (accept) begin
                        state_q <= ST_DACK;
                        pull_q  <= 1'b1;
                     end else begin
                        state_q <= ST_SKIP;
                     end
                  end
               end
               ST_AACK, ST_DACK: begin
                  if (ev_rise) begin
                     ack_clk_q <= 1'b1;
                  end
                  if (ev_fall && ack_clk_q) begin
                     pull_q    <= 1'b0;
                     ack_clk_q <= 1'b0;
                     state_q   <= ((state_q == ST_AACK) && rw_bit) ? ST_SKIP : ST_DATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull_o = pull_q;
   assign data_stb_o = stb_q;
   assign addr_hit_o = hit_q;
   assign data_o     = rx_byte;

   AST_PULL_STARTS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> $past(ev_fall)) else $error("pull began off a clock fall"); // R2

   AST_PULL_ENDS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull_o) |-> $past(ev_fall || ev_start || ev_stop))
      else $error("pull ended off a clock fall"); // R2

   AST_COND_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start || ev_stop) |=> !sda_pull_o) else $error("pull held over START/STOP"); // R11

   AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP) |-> (!sda_pull_o && !data_stb_o)) else $error("activity while skipping"); // R8

   AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      data_stb_o |=> !data_stb_o) else $error("strobe longer than one cycle"); // R4

endmodule

// File: tb/mgmt_tgt_ack_test.sv
module mgmt_tgt_ack_test;

   localparam logic [6:0] OWN = 7'h2C;
   localparam int M_NONE = 0;
   localparam int M_OK   = 1;
   localparam int M_BAD  = 2;
   localparam int M_FBAD = 3;
   localparam int M_LATE = 4;
   localparam int PH     = 4;

   typedef struct packed {
      logic [6:0] a;
      logic       rw;
      logic [7:0] d;
      logic [2:0] m;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{7'h2C, 1'b0, 8'hA5, 3'd1},
      '{7'h2C, 1'b0, 8'h3C, 3'd2},
      '{7'h2C, 1'b0, 8'hF0, 3'd0},
      '{7'h13, 1'b0, 8'h77, 3'd1},
      '{7'h2C, 1'b1, 8'h55, 3'd1},
      '{7'h2C, 1'b0, 8'h0F, 3'd3},
      '{7'h2C, 1'b0, 8'h81, 3'd4},
      '{7'h6C, 1'b0, 8'hFF, 3'd1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       h_scl = 1'b1;
   logic       h_sda = 1'b1;
   logic       resp_vld = 1'b0;
   logic       resp_ok = 1'b0;
   logic       sda_pull, addr_hit, data_stb;
   logic [7:0] data;
   logic       bus_sda;

   int tests = 0;
   int fails = 0;
   int stb_cnt = 0;
   int hit_cnt = 0;
   logic [7:0] last_data = 8'h00;
   logic       pull_seen = 1'b0;

   always #2 clk = ~clk;

   assign bus_sda = h_sda & ~sda_pull;

   mgmt_tgt_ack uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (h_scl),
      .sda_i      (bus_sda),
      .own_addr_i (OWN),
      .resp_vld_i (resp_vld),
      .resp_ok_i  (resp_ok),
      .sda_pull_o (sda_pull),
      .addr_hit_o (addr_hit),
      .data_o     (data),
      .data_stb_o (data_stb)
   );

   always @(negedge clk) begin
      if (data_stb) begin
         stb_cnt   <= stb_cnt + 1;
         last_data <= data;
      end
      if (addr_hit) hit_cnt <= hit_cnt + 1;
      if (sda_pull) pull_seen <= 1'b1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      h_sda = 1'b1; wc(PH);
      h_scl = 1'b1; wc(PH);
      h_sda = 1'b0; wc(PH);
      h_scl = 1'b0; wc(PH);
   endtask

   task automatic do_stop();
      h_sda = 1'b0; wc(PH);
      h_scl = 1'b1; wc(PH);
      h_sda = 1'b1; wc(PH);
   endtask

   task automatic pulse_resp(input logic ok);
      resp_vld = 1'b1; resp_ok = ok; wc(1);
      resp_vld = 1'b0; resp_ok = 1'b0;
   endtask

   task automatic put_bit(input logic b, input bit last, input int mode);
      h_sda = b; wc(PH);
      h_scl = 1'b1; wc(1);
      if (last && mode == M_OK)        pulse_resp(1'b1);
      else if (last && mode == M_BAD)  pulse_resp(1'b0);
      else if (last && mode == M_FBAD) begin pulse_resp(1'b0); pulse_resp(1'b1); end
      else wc(1);
      if (!(last && mode == M_FBAD)) wc(1);
      wc(PH - 3);
      h_scl = 1'b0;
      if (last && mode == M_LATE) begin wc(1); pulse_resp(1'b1); wc(PH - 2); end
      else wc(PH);
   endtask

   task automatic send_byte(input logic [7:0] b, input int mode, output logic acked);
      for (int i = 7; i >= 0; i--) put_bit(b[i], (i == 0), mode);
      h_sda = 1'b1; wc(PH);
      h_scl = 1'b1; wc(2);
      acked = ~bus_sda;
      wc(PH - 2);
      h_scl = 1'b0; wc(PH);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) put_bit(b[i], 1'b0, M_NONE);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic ack;
      int   s0;
      wc(5);
      // R1: reset state
      chk("R1 pull after reset", {31'd0, sda_pull}, 32'd0);
      chk("R1 strobe after reset", {31'd0, data_stb}, 32'd0);
      rst_n = 1'b1;
      wc(5);
      chk("R1 no pull before START", {31'd0, pull_seen}, 32'd0);

      // table of single-byte transfers
      for (int v = 0; v < NV; v++) begin
         logic ea, ed, es;
         ea = (VECS[v].a == OWN);
         es = ea && !VECS[v].rw;
         ed = es && (VECS[v].m == 3'(M_OK));
         s0 = stb_cnt;
         pull_seen = 1'b0;
         do_start();
         send_byte({VECS[v].a, VECS[v].rw}, M_NONE, ack);
         chk($sformatf("R2/R3 addr ack vec%0d", v), {31'd0, ack}, {31'd0, ea});
         send_byte(VECS[v].d, int'(VECS[v].m), ack);
         chk($sformatf("R5/R6/R7/R10 data ack vec%0d", v), {31'd0, ack}, {31'd0, ed});
         chk($sformatf("R4/R10 strobe count vec%0d", v), stb_cnt - s0, {31'd0, es});
         if (es) chk($sformatf("R4 data value vec%0d", v), {24'd0, last_data}, {24'd0, VECS[v].d});
         if (!ea) chk($sformatf("R3 no pull vec%0d", v), {31'd0, pull_seen}, 32'd0);
         do_stop();
      end

      // R8: per-byte decision, last byte rejected, later byte ignored
      s0 = stb_cnt;
      do_start();
      send_byte({OWN, 1'b0}, M_NONE, ack);
      chk("R2 addr ack multi", {31'd0, ack}, 32'd1);
      send_byte(8'h11, M_OK, ack);
      chk("R5 byte1 ack", {31'd0, ack}, 32'd1);
      send_byte(8'h22, M_OK, ack);
      chk("R5 byte2 ack", {31'd0, ack}, 32'd1);
      send_byte(8'h33, M_BAD, ack);
      chk("R8 last byte nack", {31'd0, ack}, 32'd0);
      chk("R4 data after three bytes", {24'd0, last_data}, 32'h33);
      pull_seen = 1'b0;
      send_byte(8'h44, M_OK, ack);
      chk("R8 byte after nack", {31'd0, ack}, 32'd0);
      chk("R8 no pull after nack", {31'd0, pull_seen}, 32'd0);
      chk("R8 strobe count", stb_cnt - s0, 32'd3);
      do_stop();

      // R9: repeated START with no STOP
      do_start();
      send_byte({OWN, 1'b0}, M_NONE, ack);
      send_byte(8'h5A, M_BAD, ack);
      chk("R9 setup nack", {31'd0, ack}, 32'd0);
      do_start();
      send_byte({OWN, 1'b0}, M_NONE, ack);
      chk("R9 addr ack after repeated START", {31'd0, ack}, 32'd1);
      send_byte(8'h96, M_OK, ack);
      chk("R9 data ack after repeated START", {31'd0, ack}, 32'd1);
      chk("R9 data value", {24'd0, last_data}, 32'h96);
      do_stop();

      // R11: STOP in the middle of a byte
      s0 = hit_cnt;
      do_start();
      send_byte({OWN, 1'b0}, M_NONE, ack);
      send_bits(8'hFF, 4);
      h_scl = 1'b0;
      do_stop();
      do_start();
      send_byte({OWN, 1'b0}, M_NONE, ack);
      chk("R11 addr ack after aborted byte", {31'd0, ack}, 32'd1);
      send_byte(8'hC3, M_OK, ack);
      chk("R11 data ack after abort", {31'd0, ack}, 32'd1);
      chk("R11 fresh byte alignment", {24'd0, last_data}, 32'hC3);
      chk("R2 address hit pulses", hit_cnt - s0, 32'd2);
      do_stop();
      wc(PH);
      chk("R11 released after STOP", {31'd0, sda_pull}, 32'd0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule